// File: doc/BRIEF.md
# Signed Step Counter with Overflow Hold

The block holds a two's-complement value `q` and moves it by a signed step size on request. A synchronous reset loads a signed start value. After that, each clock edge with only `up` high adds the step `b`, and each edge with only `dn` high subtracts it. Every candidate result is formed one bit wider than the datapath, so that signed overflow is found exactly.

A step whose result would fall outside the signed range is refused. `q` keeps its old value and a sticky overflow flag is raised. Because of this, pressing one direction over and over brings `q` to rest at the last value that can still be reached, and it never wraps around. The block is meant for control or test logic that needs bounded signed accumulation and must not wrap silently.

Top module: `sat_step_counter`

## Requirements
- R1: On a clock edge with `rst` high, `q` takes the signed value of `a` and `ovf` clears to 0.
- R2: On an edge with `up` high and `dn` low, `q` becomes `q + b`, both read as signed two's complement, when the sum lies in [-2^(W-1), 2^(W-1)-1].
- R3: On an edge with `dn` high and `up` low, `q` becomes `q - b` when the difference is in range. The step is formed as `q` plus the inverted `b` plus one, so `b = -2^(W-1)` is handled correctly.
- R4: When `up` and `dn` are both low, or both high, `q` and `ovf` keep their values.
- R5: A step whose exact signed result is out of range leaves `q` unchanged and sets `ovf` to 1 on that edge.
- R6: Once set, `ovf` stays 1 until the next reset. Later in-range steps still update `q`.
- R7: Repeated steps in one direction bring `q` to a fixed value, the last one within range. For example, with W=8, a=29 and b=-17, repeated `up` settles at -124; with a=53 and b=13 it settles at 118.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset; loads `a` |
| up | input | 1 | Add-step request |
| dn | input | 1 | Subtract-step request |
| a | input | W | Signed start value |
| b | input | W | Signed step size |
| q | output | W | Signed counter value |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The bench builds the counter with W=8. The full range from -128 to +127 is then only a few steps from any start value, so random walks hit both range limits often. The directed cases can name the extreme values outright: a step of -128 in both directions, +127 plus one, and a start at -128. A bench model in plain integer arithmetic predicts every edge, including the settle points of long one-direction runs.

// File: rtl/sat_step_counter.sv
module sat_step_counter #(
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                up,
  input  logic                dn,
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] q,
  output logic                ovf
);
  localparam int XW = W + 1;

  logic signed [XW-1:0] q_x, b_x, addend, cand;
  logic                 step, out_of_range;

  assign step         = up ^ dn;
  assign q_x          = {q[W-1], q};
  assign b_x          = {b[W-1], b};
  assign addend       = up ? b_x : (~b_x + 1'b1);
  assign cand         = q_x + addend;
  assign out_of_range = cand[XW-1] ^ cand[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= a;
      ovf <= 1'b0;
    end else if (step) begin
      if (out_of_range) ovf <= 1'b1;
      else              q   <= cand[W-1:0];
    end
  end
endmodule

// File: rtl/sat_step_counter_chk.sv
module sat_step_counter_chk #(
  parameter int W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                up,
  input logic                dn,
  input logic signed [W-1:0] b,
  input logic signed [W-1:0] q,
  input logic                ovf
);
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (up == dn) |=> ($stable(q) && $stable(ovf)));

  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

  p_hold_on_ovf_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $stable(q));

  p_up_nonneg_r2: assert property (@(posedge clk) disable iff (rst)
    (up && !dn && !b[W-1]) |=> ($signed(q) >= $signed($past(q))));

  p_dn_nonneg_r3: assert property (@(posedge clk) disable iff (rst)
    (dn && !up && !b[W-1]) |=> ($signed(q) <= $signed($past(q))));
endmodule

bind sat_step_counter sat_step_counter_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .up(up), .dn(dn), .b(b), .q(q), .ovf(ovf)
);

// File: tb/sat_step_counter_test.sv
`timescale 1ns/1ps
module sat_step_counter_test;
  logic clk = 1'b0;
  logic rst = 1'b1, up = 1'b0, dn = 1'b0;
  logic signed [7:0] a = '0, b = '0;
  logic signed [7:0] q;
  logic ovf;

  int runs = 0, fails = 0;
  int mq = 0;
  bit mo = 1'b0;

  sat_step_counter #(.W(8)) uut (
    .clk(clk), .rst(rst), .up(up), .dn(dn), .a(a), .b(b), .q(q), .ovf(ovf)
  );

  always #2.5 clk = ~clk;

  function automatic int next_val(int cur, bit u, int bv);
    return u ? cur + bv : cur - bv;
  endfunction

  task automatic check(string tag, int got_q, bit got_o, int exp_q, bit exp_o);
    runs++;
    if (got_q != exp_q || got_o != exp_o) begin
      fails++;
      $display("FAIL %s: q=%0d ovf=%0d expected q=%0d ovf=%0d", tag, got_q, got_o, exp_q, exp_o);
    end
  endtask

  task automatic cyc(bit r, bit u, bit d, int av, int bv, string tag);
    int nv;
    @(negedge clk);
    rst = r; up = u; dn = d; a = av[7:0]; b = bv[7:0];
    @(posedge clk);
    #1;
    if (r) begin
      mq = av; mo = 1'b0;
    end else if (u != d) begin
      nv = next_val(mq, u, bv);
      if (nv > 127 || nv < -128) mo = 1'b1;
      else mq = nv;
    end
    check(tag, int'(q), ovf, mq, mo);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: q=%0d ovf=%0d expected finish", q, ovf);
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    int s;
    s = $urandom(1234);
    cyc(1, 0, 0, -47, -43, "R1 reset load");
    cyc(0, 1, 1, -47, -43, "R4 both high");
    cyc(0, 0, 0, -47, -43, "R4 idle");
    cyc(0, 0, 1, -47, -43, "R3 dn negative b");
    cyc(0, 1, 0, -47, -43, "R2 up negative b");

    cyc(1, 0, 0, 127, 1, "R1 reset max");
    cyc(0, 1, 0, 127, 1, "R5 up past max");
    cyc(0, 0, 1, 127, 1, "R6 sticky after in-range dn");
    cyc(0, 1, 1, 127, 1, "R4 both high with ovf set");

    cyc(1, 0, 0, -128, -128, "R1 reset min");
    cyc(0, 0, 1, -128, -128, "R3 dn b=-128 to zero");
    cyc(0, 0, 1, -128, -128, "R5 dn b=-128 overflow");
    cyc(1, 0, 0, 0, -128, "R1 reset zero");
    cyc(0, 0, 1, 0, -128, "R5 zero minus -128");

    cyc(1, 0, 0, 29, -17, "R1 reset 29");
    for (int i = 0; i < 20; i++) cyc(0, 1, 0, 29, -17, "R7 up run b=-17");
    check("R7 settle -124", int'(q), ovf, -124, 1'b1);

    cyc(1, 0, 0, 53, 13, "R1 reset 53");
    for (int i = 0; i < 20; i++) cyc(0, 1, 0, 53, 13, "R7 up run b=13");
    check("R7 settle 118", int'(q), ovf, 118, 1'b1);

    cyc(1, 0, 0, -17, 37, "R1 reset -17");
    for (int i = 0; i < 10; i++) cyc(0, 0, 1, -17, 37, "R7 dn run b=37");
    check("R7 settle -128", int'(q), ovf, -128, 1'b1);

    for (int i = 0; i < 3000; i++) begin
      int av, bv;
      bit r, u, d;
      av = int'($urandom_range(255)) - 128;
      bv = int'($urandom_range(255)) - 128;
      if ($urandom_range(3) == 0) bv = int'($urandom_range(15)) - 8;
      r = ($urandom_range(63) == 0);
      u = $urandom_range(1);
      d = $urandom_range(1);
      cyc(r, u, d, av, bv, "R2 R3 R5 R6 random");
    end

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule